// File: doc/BRIEF.md
# Bridge Diagonal Polarity Generator

This block produces the two slow polarity enables that choose which diagonal of a full-bridge inverter conducts. A prescaler divides the system clock into counter ticks, and an up-counter that wraps at the end of each period splits every period into two equal halves. One output, the primary, is assigned to one half. The other output, the complement, is assigned to the other half. At each change of half both outputs are held low for a programmable number of system clock cycles, so the two diagonals can never conduct at the same time.

With the default parameters and a 24 MHz clock, the prescaler divides by 480 and the counter spans 1000 ticks. This gives a 20 ms (50 Hz) square pair, and each output is nominally high for 10 ms. A dead-time setting of 7 cycles gives roughly 300 ns of gap. The dead-time setting is taken in only while the block is idle and at each counter wrap, so an update never lands in the middle of a transition. A sticky flag reports any cycle in which both outputs are high.

Top module: `bridge_polarity_gen`

## Requirements
- R1: While reset is asserted, and afterwards until enable is first seen high, `pos_o`, `neg_o` and `overlap_o` are all 0.
- R2: While enabled, both outputs repeat every PRESCALE*PERIOD clock cycles. With a constant dead time D, each output is high for PRESCALE*PERIOD/2 - D cycles in every period.
- R3: `pos_o` and `neg_o` are never 1 in the same cycle.
- R4: Count cycles from the cycle in which enable is first seen high (cycle 0), with t = cycle mod (PRESCALE*PERIOD) and H = PRESCALE*(PERIOD/2). `pos_o` falls at t = 1 and `neg_o` rises D cycles later. `neg_o` falls at t = H+1 and `pos_o` rises D cycles later. Both outputs stay low for exactly D cycles at each of the two transitions.
- R5: A dead-time setting of 0 swaps the outputs in a single cycle, with no low gap.
- R6: `dt_i` is sampled while disabled and in the last cycle of each period only. A value applied in mid-period has no effect on the transition at mid-period. It takes effect from the next wrap transition (`pos_o` falling).
- R7: When enable is seen low, both outputs are 0 from the next cycle on. After enable returns, `neg_o` rises D cycles after cycle 0 and stays high through t = H. `pos_o` stays low until cycle H+1+D.
- R8: `overlap_o` is a sticky flag that would set on any cycle with both outputs high. On a correct run it stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; one period is the dead-time unit |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Run enable; low forces both outputs low |
| dt_i | input | DT_W | Dead time in clock cycles |
| pos_o | output | 1 | Primary diagonal enable, active high |
| neg_o | output | 1 | Complementary diagonal enable, active high |
| overlap_o | output | 1 | Sticky flag: both enables were seen high together |

## Verification
The counter wrap that samples a new dead time falls in the same cycle boundary as the transition where `pos_o` falls. The bench provokes this by changing `dt_i` part way through a period, after which the wrap and the gap start coincide. It judges the result by checking that the mid-period gap still has the old length and the gap after the wrap has the new length. A second coincidence is a disable that arrives while one output is high. The bench checks that the cut-off takes priority over the running waveform from the next cycle.

// File: rtl/bpg_pkg.sv
`timescale 1ns/1ps
package bpg_pkg;
  // which diagonal the reference currently selects
  typedef enum logic {
    LEG_NEG = 1'b0,
    LEG_POS = 1'b1
  } leg_e;
endpackage

// File: rtl/bpg_prescaler.sv
`timescale 1ns/1ps
module bpg_prescaler #(
  parameter int PRESCALE = 480
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0] pc_q, pc_d;
  logic            last;

  assign last   = (pc_q == PS_LAST);
  assign tick_o = run_i && last;

  always_comb begin
    pc_d = pc_q;
    if (!run_i || last) pc_d = '0;
    else                pc_d = pc_q + PS_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  // R2: the divider never runs past its last state
  assert_ps_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= PS_LAST);
endmodule

// File: rtl/bpg_period_ctr.sv
`timescale 1ns/1ps
module bpg_period_ctr
  import bpg_pkg::*;
#(
  parameter int PERIOD  = 1000,
  parameter int COMPARE = PERIOD / 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic wrap_o,
  output leg_e leg_o
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] C_LAST = CW'(PERIOD - 1);
  localparam logic [CW-1:0] C_CMP  = CW'(COMPARE);

  logic [CW-1:0] cnt_q, cnt_d;

  assign wrap_o = tick_i && (cnt_q == C_LAST);
  assign leg_o  = (cnt_q >= C_CMP) ? LEG_POS : LEG_NEG;

  always_comb begin
    cnt_d = cnt_q;
    if (!run_i)      cnt_d = '0;
    else if (wrap_o) cnt_d = '0;
    else if (tick_i) cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  // R2: counter stays inside one period
  assert_cnt_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= C_LAST);
endmodule

// File: rtl/bpg_deadband.sv
`timescale 1ns/1ps
module bpg_deadband
  import bpg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  leg_e            leg_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            pos_o,
  output logic            neg_o
);
  leg_e            ref_q, ref_d;
  logic [DT_W-1:0] gap_q, gap_d;
  logic            settled;

  assign settled = (gap_q == '0);
  assign pos_o   = run_i && (ref_q == LEG_POS) && settled;
  assign neg_o   = run_i && (ref_q == LEG_NEG) && settled;

  always_comb begin
    ref_d = ref_q;
    gap_d = gap_q;
    if (!run_i) begin
      ref_d = LEG_NEG;           // restart from primary-low side
      gap_d = dt_i;              // with a full gap
    end else if (leg_i != ref_q) begin
      ref_d = leg_i;
      gap_d = dt_i;
    end else if (!settled) begin
      gap_d = gap_q - DT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= LEG_NEG;
      gap_q <= '0;
    end else begin
      ref_q <= ref_d;
      gap_q <= gap_d;
    end
  end

  // R4: a nonzero gap means the rising side is not on when the other drops
  assert_gap_on_neg_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(neg_o) && run_i && dt_i != '0) |-> !pos_o);
  assert_gap_on_pos_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pos_o) && run_i && dt_i != '0) |-> !neg_o);
endmodule

// File: rtl/bridge_polarity_gen.sv
`timescale 1ns/1ps
module bridge_polarity_gen
  import bpg_pkg::*;
#(
  parameter int PRESCALE = 480,
  parameter int PERIOD   = 1000,
  parameter int DT_W     = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [DT_W-1:0] dt_i,
  output logic            pos_o,
  output logic            neg_o,
  output logic            overlap_o
);
  localparam int COMPARE = PERIOD / 2;

  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic            run_q;
  logic [DT_W-1:0] dt_q, dt_d;
  logic            flag_q, flag_d;
  logic            tick, wrap;
  leg_e            leg;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  always_comb begin
    dt_d = dt_q;
    if (!run_q || wrap) dt_d = dt_i;   // sample only idle or at wrap
    flag_d = flag_q || (pos_o && neg_o);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      dt_q   <= '0;
      flag_q <= 1'b0;
    end else begin
      run_q  <= en_i;
      dt_q   <= dt_d;
      flag_q <= flag_d;
    end
  end

  assign overlap_o = flag_q;

  bpg_prescaler #(.PRESCALE(PRESCALE)) u_presc (
    .clk_i (clk_i), .rst_ni(rst_n), .run_i(run_q), .tick_o(tick)
  );

  bpg_period_ctr #(.PERIOD(PERIOD), .COMPARE(COMPARE)) u_ctr (
    .clk_i (clk_i), .rst_ni(rst_n), .run_i(run_q), .tick_i(tick),
    .wrap_o(wrap), .leg_o(leg)
  );

  bpg_deadband #(.DT_W(DT_W)) u_dead (
    .clk_i (clk_i), .rst_ni(rst_n), .run_i(run_q), .leg_i(leg),
    .dt_i  (dt_q), .pos_o(pos_o), .neg_o(neg_o)
  );

  // R3: diagonals never enabled together
  assert_no_overlap_R3: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(pos_o && neg_o));
  // R7: disable cuts both outputs on the next cycle
  assert_disable_low_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    !en_i |=> (!pos_o && !neg_o));
  // R6: setting is frozen between wraps while running
  assert_dt_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (run_q && !wrap) |=> $stable(dt_q));
  // R8: the sticky flag never sets
  assert_flag_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_n)
    !overlap_o);
endmodule

// File: tb/bridge_polarity_gen_test.sv
`timescale 1ns/1ps
module bridge_polarity_gen_test;
  localparam int PS   = 4;
  localparam int PER  = 20;
  localparam int DTW  = 8;
  localparam int FULL = PS * PER;
  localparam int HALF = PS * (PER / 2);

  logic           clk = 1'b0;
  logic           rst_n;
  logic           en;
  logic [DTW-1:0] dt;
  logic           pos, neg, ovl;
  int             checks = 0;
  int             errors = 0;

  always #2.5 clk = ~clk;

  bridge_polarity_gen #(.PRESCALE(PS), .PERIOD(PER), .DT_W(DTW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .dt_i(dt),
    .pos_o(pos), .neg_o(neg), .overlap_o(ovl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Enable from idle and compare against the expected waveform each cycle.
  task automatic run_wave(input string req, input int d0, input int ncyc,
                          input int c1_k, input int c1_v,
                          input int c2_k, input int c2_v,
                          output int pos_win, output int neg_win);
    int d_cur, d_next, t, m;
    bit ep, en_x;
    pos_win = 0; neg_win = 0;
    @(negedge clk); en = 1'b0; dt = DTW'(d0);
    repeat (3) @(negedge clk);
    en = 1'b1;
    d_cur = d0; d_next = d0;
    for (int k = 0; k < ncyc; k++) begin
      @(negedge clk);
      t = k % FULL; m = k / FULL;
      if (t == 0 && m > 0) d_cur = d_next;
      if (m == 0) begin
        en_x = (t >= d_cur) && (t <= HALF);
        ep   = (t >= HALF + 1 + d_cur);
      end else begin
        en_x = (t >= 1 + d_cur) && (t <= HALF);
        ep   = (t == 0) || (t >= HALF + 1 + d_cur);
      end
      chk(pos == ep,   req, $sformatf("pos_o cycle %0d", k), pos, ep);
      chk(neg == en_x, req, $sformatf("neg_o cycle %0d", k), neg, en_x);
      chk(!(pos && neg), "R3", "both high", 1, 0);
      chk(ovl == 1'b0, "R8", "overlap flag", ovl, 0);
      if (k >= FULL && k < 2 * FULL) begin
        pos_win += int'(pos);
        neg_win += int'(neg);
      end
      if (k == c1_k) dt = DTW'(c1_v);
      if (k == c2_k) dt = DTW'(c2_v);
      if (t == FULL - 1) d_next = dt;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; dt = DTW'(7);
    repeat (4) @(negedge clk);
    chk(pos == 0 && neg == 0, "R1", "outputs in reset", {pos, neg}, 0);
    chk(ovl == 0, "R1", "flag in reset", ovl, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(pos == 0 && neg == 0, "R1", "outputs idle after reset", {pos, neg}, 0);
    chk(ovl == 0, "R1", "flag idle after reset", ovl, 0);
  endtask

  task automatic t_main();
    int pw, nw;
    run_wave("R4", 7, 3 * FULL, -1, 0, -1, 0, pw, nw);
    chk(pw == HALF - 7, "R2", "pos_o high cycles per period", pw, HALF - 7);
    chk(nw == HALF - 7, "R2", "neg_o high cycles per period", nw, HALF - 7);
  endtask

  task automatic t_wide();
    int pw, nw;
    run_wave("R4", 20, 2 * FULL, -1, 0, -1, 0, pw, nw);
    chk(pw == HALF - 20, "R2", "pos_o high cycles, wide gap", pw, HALF - 20);
  endtask

  task automatic t_zero();
    int pw, nw;
    run_wave("R5", 0, 2 * FULL + 4, -1, 0, -1, 0, pw, nw);
    chk(pw + nw == FULL, "R5", "no gap cycles with zero setting", pw + nw, FULL);
  endtask

  task automatic t_resample();
    int pw, nw;
    // change to 6 mid-period (takes effect at wrap 80), then to 2 before
    // the mid transition at 120 (must not affect it; used at wrap 160)
    run_wave("R6", 3, 3 * FULL, 60, 6, 100, 2, pw, nw);
    chk(pw == HALF - 6, "R6", "pos_o cycles in period after resample", pw, HALF - 6);
  endtask

  task automatic t_disable();
    int pw, nw;
    run_wave("R7", 5, 51, -1, 0, -1, 0, pw, nw);
    chk(pos == 1, "R7", "pos_o high before disable", pos, 1);
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(pos == 0 && neg == 0, "R7", "outputs after disable", {pos, neg}, 0);
    end
    run_wave("R7", 4, HALF + 8, -1, 0, -1, 0, pw, nw);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog timeout actual running expected finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_main();
    t_wide();
    t_zero();
    t_resample();
    t_disable();
    chk(ovl == 0, "R8", "overlap flag at end", ovl, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule